// File: doc/BRIEF.md
# 8-bit Register Load Execution Unit

This block is a small sequencer and register file. It fetches and executes the single-byte register-load subset of a classic 8-bit processor. It reads opcode and data bytes from a byte-wide memory port and drives a 16-bit address.

It keeps seven 8-bit working registers, named A, B, C, D, E, H and L, together with a program counter and a halted state. Three load forms are executed:

- a register-to-register copy;
- a load of an immediate byte that follows the opcode;
- a load from the memory byte addressed by the H:L pair.

One opcode stops the sequencer. Every other opcode is consumed as a one-byte no-operation. The block has no flag register, so none of the loads can change a flag.

Every memory access takes one clock. The address is presented in one cycle, and the read data is taken at the next rising edge. Debug outputs show every register, the program counter and the halted state, so that the surrounding logic or a testbench can watch execution.

Top module: `reg_load_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, the program counter, all seven registers and the halted output read zero, and mem_addr_o reads 0x0000.
- R2: An opcode 01 ddd sss, with neither ddd nor sss equal to 110, copies the register selected by sss (bits 2:0) into the register selected by ddd (bits 5:3). It takes one cycle and advances the program counter by 1.
- R3: An opcode 00 ddd 110, with ddd not equal to 110, writes the byte that follows it into the register selected by ddd. It takes two cycles and advances the program counter by 2.
- R4: An opcode 01 ddd 110, with ddd not equal to 110, puts {H,L} on mem_addr_o in its second cycle and writes the byte read there into register ddd. It takes two cycles and advances the program counter by 1.
- R5: Opcode 0x76 sets halted_o after one cycle and advances the program counter by 1. From then on the program counter, the registers and mem_addr_o stay frozen until reset.
- R6: A copy whose source and destination codes are equal (0x40, 0x49, 0x7F and similar) completes in one cycle and leaves the register unchanged.
- R7: Every opcode outside R2 to R5 is a one-byte no-operation. This includes 0x00, 0x36, and 0x70 to 0x77 except 0x76. Such an opcode takes one cycle, advances the program counter by 1 and writes no register.
- R8: The 3-bit register codes are B=000, C=001, D=010, E=011, H=100, L=101 and A=111. Code 110 names no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory byte address |
| mem_rdata_i | input | 8 | Memory read byte, sampled at the next rising edge |
| dbg_a_o | output | 8 | Register A |
| dbg_b_o | output | 8 | Register B |
| dbg_c_o | output | 8 | Register C |
| dbg_d_o | output | 8 | Register D |
| dbg_e_o | output | 8 | Register E |
| dbg_h_o | output | 8 | Register H |
| dbg_l_o | output | 8 | Register L |
| dbg_pc_o | output | 16 | Program counter |
| halted_o | output | 1 | Halted state, cleared only by reset |

## Verification
The assertions check several rules on every cycle:

- the decoder never selects more than one instruction form;
- the register file holds its contents in any cycle without a write;
- the program counter steps by one after each opcode fetch, and again after an immediate byte;
- the indirect read cycle drives {H,L} onto the address;
- the halted state is sticky, with a frozen program counter.

Only the bench scenarios can show the following:

- that the right register receives the right byte for each code;
- that whole instruction streams take the expected number of cycles;
- that no-operation opcodes, including the memory-destination forms, leave the registers alone;
- that reset is the only way out of the halted state.

// File: rtl/rlu_pkg.sv
package rlu_pkg;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_MEM = 3'b110;
  localparam logic [7:0] OP_HALT = 8'h76;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_IMM,
    ST_MEMRD,
    ST_HALT
  } state_e;

  typedef struct packed {
    logic              copy;
    logic              imm;
    logic              ind;
    logic              halt;
    logic [CODE_W-1:0] dst;
    logic [CODE_W-1:0] src;
  } dec_t;
endpackage

// File: rtl/rlu_decode.sv
module rlu_decode
  import rlu_pkg::*;
(
  input  logic [7:0] op_i,
  output dec_t       dec_o
);
  logic [1:0]        grp;
  logic [CODE_W-1:0] dst;
  logic [CODE_W-1:0] src;

  assign grp = op_i[7:6];
  assign dst = op_i[5:3];
  assign src = op_i[2:0];

  always_comb begin
    dec_o      = '0;
    dec_o.dst  = dst;
    dec_o.src  = src;
    if (op_i == OP_HALT) begin
      dec_o.halt = 1'b1;
    end else if (grp == 2'b01 && dst != CODE_MEM) begin
      if (src == CODE_MEM) dec_o.ind  = 1'b1;
      else                 dec_o.copy = 1'b1;
    end else if (grp == 2'b00 && src == CODE_MEM && dst != CODE_MEM) begin
      dec_o.imm = 1'b1;
    end
  end

  // R8: at most one form is selected per opcode
  always_comb begin
    a_r8_dec_onehot: assert ($onehot0({dec_o.copy, dec_o.imm, dec_o.ind, dec_o.halt}))
      else $error("decoder selected more than one instruction form");
  end
endmodule

// File: rtl/rlu_regfile.sv
module rlu_regfile
  import rlu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NREG  = 2 ** CODE_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [CODE_W-1:0]            waddr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [CODE_W-1:0]            raddr_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [NREG-1:0][DATA_W-1:0]  regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == int'(CODE_MEM)) begin : g_hole
      assign regs_o[i] = '0;
    end else begin : g_ff
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 q <= '0;
        else if (we_i && waddr_i == CODE_W'(i))      q <= wdata_i;
      end
      assign regs_o[i] = q;
    end
  end

  assign rdata_o = regs_o[raddr_i];

  // R7: registers hold in any cycle without a write
  a_r7_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> regs_o == $past(regs_o))
    else $error("register changed without a write");
endmodule

// File: rtl/rlu_seq.sv
module rlu_seq
  import rlu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_copy_i,
  input  logic              op_imm_i,
  input  logic              op_ind_i,
  input  logic              op_halt_i,
  input  logic [CODE_W-1:0] op_dst_i,
  output state_e            state_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              use_hl_o,
  output logic              we_o,
  output logic              wsel_mem_o,
  output logic [CODE_W-1:0] waddr_o
);
  state_e            state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [CODE_W-1:0] dst_q, dst_d;

  always_comb begin
    state_d    = state_q;
    pc_d       = pc_q;
    dst_d      = dst_q;
    we_o       = 1'b0;
    wsel_mem_o = 1'b0;
    waddr_o    = op_dst_i;
    use_hl_o   = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        pc_d = pc_q + 1'b1;
        if (op_halt_i) begin
          state_d = ST_HALT;
        end else if (op_copy_i) begin
          we_o = 1'b1;
        end else if (op_imm_i) begin
          dst_d   = op_dst_i;
          state_d = ST_IMM;
        end else if (op_ind_i) begin
          dst_d   = op_dst_i;
          state_d = ST_MEMRD;
        end
      end
      ST_IMM: begin
        pc_d       = pc_q + 1'b1;
        we_o       = 1'b1;
        wsel_mem_o = 1'b1;
        waddr_o    = dst_q;
        state_d    = ST_FETCH;
      end
      ST_MEMRD: begin
        use_hl_o   = 1'b1;
        we_o       = 1'b1;
        wsel_mem_o = 1'b1;
        waddr_o    = dst_q;
        state_d    = ST_FETCH;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      dst_q   <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      dst_q   <= dst_d;
    end
  end

  assign state_o = state_q;
  assign pc_o    = pc_q;

  // R2/R7: every opcode fetch advances the program counter by one
  a_r7_pc_step_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FETCH |=> pc_q == ADDR_W'($past(pc_q) + 1'b1))
    else $error("pc did not step after fetch");

  // R3: immediate opcode moves to the operand cycle
  a_r3_imm_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && op_imm_i) |=> state_q == ST_IMM)
    else $error("immediate operand cycle missing");

  // R5: halt is sticky with a frozen pc
  a_r5_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HALT |=> (state_q == ST_HALT && $stable(pc_q)))
    else $error("left halt without reset");
endmodule

// File: rtl/reg_load_unit.sv
module reg_load_unit
  import rlu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int NREG   = 2 ** CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] dbg_a_o,
  output logic [DATA_W-1:0] dbg_b_o,
  output logic [DATA_W-1:0] dbg_c_o,
  output logic [DATA_W-1:0] dbg_d_o,
  output logic [DATA_W-1:0] dbg_e_o,
  output logic [DATA_W-1:0] dbg_h_o,
  output logic [DATA_W-1:0] dbg_l_o,
  output logic [ADDR_W-1:0] dbg_pc_o,
  output logic              halted_o
);
  localparam int IDX_B = 0, IDX_C = 1, IDX_D = 2, IDX_E = 3;
  localparam int IDX_H = 4, IDX_L = 5, IDX_A = 7;

  dec_t                       dec;
  state_e                     state;
  logic [ADDR_W-1:0]          pc;
  logic                       use_hl, we, wsel_mem;
  logic [CODE_W-1:0]          waddr;
  logic [DATA_W-1:0]          rd_data, wdata;
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [ADDR_W-1:0]          hl;

  rlu_decode u_dec (
    .op_i  (mem_rdata_i),
    .dec_o (dec)
  );

  rlu_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_copy_i  (dec.copy),
    .op_imm_i   (dec.imm),
    .op_ind_i   (dec.ind),
    .op_halt_i  (dec.halt),
    .op_dst_i   (dec.dst),
    .state_o    (state),
    .pc_o       (pc),
    .use_hl_o   (use_hl),
    .we_o       (we),
    .wsel_mem_o (wsel_mem),
    .waddr_o    (waddr)
  );

  assign wdata = wsel_mem ? mem_rdata_i : rd_data;

  rlu_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (dec.src),
    .rdata_o (rd_data),
    .regs_o  (regs)
  );

  assign hl         = {regs[IDX_H], regs[IDX_L]};
  assign mem_addr_o = use_hl ? hl : pc;
  assign dbg_a_o    = regs[IDX_A];
  assign dbg_b_o    = regs[IDX_B];
  assign dbg_c_o    = regs[IDX_C];
  assign dbg_d_o    = regs[IDX_D];
  assign dbg_e_o    = regs[IDX_E];
  assign dbg_h_o    = regs[IDX_H];
  assign dbg_l_o    = regs[IDX_L];
  assign dbg_pc_o   = pc;
  assign halted_o   = (state == ST_HALT);

  // R4: indirect read cycle drives the H:L address
  a_r4_ind_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_MEMRD |-> mem_addr_o == {dbg_h_o, dbg_l_o})
    else $error("indirect read not at H:L");

  // R5: halted output frozen with a steady address
  a_r5_addr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(mem_addr_o)))
    else $error("address moved while halted");
endmodule

// File: tb/reg_load_unit_tb_top.sv
`timescale 1ns/1ps
module reg_load_unit_tb_top;
  localparam int MEMSZ = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  ra, rb, rc, rd, re, rh, rl;
  logic [15:0] pc;
  logic        halted;

  logic [7:0]  mem [MEMSZ];
  logic [7:0]  exp_r [8];
  int          exp_pc, exp_cyc, act_cyc, wp;
  int          n_checks = 0, n_errors = 0, cyc_total = 0;

  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr[11:0]];

  reg_load_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .dbg_a_o(ra), .dbg_b_o(rb), .dbg_c_o(rc), .dbg_d_o(rd), .dbg_e_o(re),
    .dbg_h_o(rh), .dbg_l_o(rl), .dbg_pc_o(pc), .halted_o(halted)
  );

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 100000) begin
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc_total);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] get_reg(int code);
    case (code)
      0: return rb;  1: return rc;  2: return rd;  3: return re;
      4: return rh;  5: return rl;  7: return ra;
      default: return 8'h00;
    endcase
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h00;
    wp = 0;
  endtask

  task automatic put(logic [7:0] b);
    mem[wp] = b;
    wp++;
  endtask

  // ISA-level reference: codes B=0 C=1 D=2 E=3 H=4 L=5 A=7, 6=memory
  task automatic model();
    int p, c;
    logic [7:0] op;
    logic [2:0] d, s;
    for (int i = 0; i < 8; i++) exp_r[i] = 8'h00;
    p = 0; c = 0;
    while (c < 2000) begin
      op = mem[p % MEMSZ]; p++; c++;
      d = op[5:3]; s = op[2:0];
      if (op == 8'h76) break;
      if (op[7:6] == 2'b01 && d != 3'd6) begin
        if (s == 3'd6) begin
          exp_r[d] = mem[{exp_r[4], exp_r[5]} % MEMSZ]; c++;
        end else exp_r[d] = exp_r[s];
      end else if (op[7:6] == 2'b00 && s == 3'd6 && d != 3'd6) begin
        exp_r[d] = mem[p % MEMSZ]; p++; c++;
      end
    end
    exp_pc = p; exp_cyc = c;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_and_check(string tag);
    model();
    do_reset();
    act_cyc = 0;
    while (!halted && act_cyc < 3000) begin
      @(negedge clk); act_cyc++;
    end
    check(tag, "halted", int'(halted), 1);
    check(tag, "cycles", act_cyc, exp_cyc);
    check(tag, "pc", int'(pc), exp_pc);
    for (int i = 0; i < 8; i++)
      if (i != 6) check(tag, $sformatf("reg code %0d", i), int'(get_reg(i)), int'(exp_r[i]));
  endtask

  task automatic t_reset();
    clear_mem();
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "pc in reset", int'(pc), 0);
    check("R1", "halted in reset", int'(halted), 0);
    check("R1", "addr in reset", int'(mem_addr), 0);
    for (int i = 0; i < 8; i++)
      if (i != 6) check("R1", $sformatf("reg %0d in reset", i), int'(get_reg(i)), 0);
  endtask

  task automatic t_imm_all();
    clear_mem();
    put(8'h06); put(8'h11); put(8'h0E); put(8'h22); put(8'h16); put(8'h33);
    put(8'h1E); put(8'h44); put(8'h26); put(8'h55); put(8'h2E); put(8'h66);
    put(8'h3E); put(8'h77); put(8'h76);
    run_and_check("R3");
    check("R8", "B code 000", int'(rb), 8'h11);
    check("R8", "C code 001", int'(rc), 8'h22);
    check("R8", "D code 010", int'(rd), 8'h33);
    check("R8", "E code 011", int'(re), 8'h44);
    check("R8", "H code 100", int'(rh), 8'h55);
    check("R8", "L code 101", int'(rl), 8'h66);
    check("R8", "A code 111", int'(ra), 8'h77);
  endtask

  task automatic t_copy();
    clear_mem();
    put(8'h3E); put(8'hA5); put(8'h06); put(8'h3C);
    put(8'h4F); put(8'h50); put(8'h59); put(8'h62); put(8'h6B); put(8'h78);
    put(8'h76);
    run_and_check("R2");
    check("R2", "C from A", int'(rc), 8'hA5);
    check("R2", "A from B", int'(ra), 8'h3C);
  endtask

  task automatic t_ind();
    clear_mem();
    put(8'h26); put(8'h0A); put(8'h2E); put(8'h12);
    put(8'h7E); put(8'h46); put(8'h2E); put(8'h13); put(8'h4E); put(8'h66);
    put(8'h76);
    mem[12'hA12] = 8'hC3;
    mem[12'hA13] = 8'h5A;
    run_and_check("R4");
    check("R4", "A from (HL)", int'(ra), 8'hC3);
    check("R4", "H from (HL)", int'(rh), 8'h5A);
  endtask

  task automatic t_same();
    clear_mem();
    put(8'h06); put(8'h9B); put(8'h0E); put(8'h21); put(8'h3E); put(8'hE7);
    put(8'h40); put(8'h49); put(8'h7F); put(8'h76);
    run_and_check("R6");
    check("R6", "B unchanged", int'(rb), 8'h9B);
    check("R6", "A unchanged", int'(ra), 8'hE7);
  endtask

  task automatic t_nop();
    clear_mem();
    put(8'h3E); put(8'h81); put(8'h00); put(8'h36); put(8'h00); put(8'h70);
    put(8'h77); put(8'h3C); put(8'h80); put(8'hC3); put(8'h76);
    run_and_check("R7");
    check("R7", "A kept", int'(ra), 8'h81);
    check("R7", "pc after nops", int'(pc), 11);
  endtask

  task automatic t_halt();
    logic [15:0] pc_h;
    clear_mem();
    put(8'h06); put(8'h12); put(8'h76); put(8'h06); put(8'hFF);
    run_and_check("R5");
    pc_h = pc;
    repeat (20) @(negedge clk);
    check("R5", "still halted", int'(halted), 1);
    check("R5", "pc frozen", int'(pc), int'(pc_h));
    check("R5", "addr frozen", int'(mem_addr), int'(pc_h));
    check("R5", "B not reloaded", int'(rb), 8'h12);
    rst_n = 1'b0;
    #1;
    check("R5", "reset clears halt", int'(halted), 0);
    check("R1", "reset clears pc", int'(pc), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_imm_all();
    t_copy();
    t_ind();
    t_same();
    t_nop();
    t_halt();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule